// File: doc/BRIEF.md
# RAM-backed serial delay line

This block behaves as a 1024-stage serial-in/serial-out shift register. It does not use a chain of flip-flops. It keeps every stage in a single-port memory that is one bit wide. A single wrapping address counter points at the oldest stored bit. Each accepted shift request starts a two-cycle sequence. In the first cycle the oldest bit is read out to the registered serial output. In the second cycle the incoming bit is written back into the same location, and the counter then moves one place forward.

A client pulses `shift_req` while `busy` is low and presents the new bit on `ser_in` in the same cycle. One shift later, `ser_out` shows the bit that went in 1024 shifts before. The memory is never cleared, so the first 1024 bits that come out after power-up have no defined value. The block also drives the memory address and the read/write line onto its ports so that the memory traffic can be observed.

Top module: `ram_shift_line`

## Requirements
- R1: Once 1024 shifts have completed, the value on `ser_out` at the end of each shift's read phase equals the `ser_in` bit accepted exactly 1024 shifts earlier.
- R2: A shift uses one address for both its read cycle and its write cycle. That address equals the number of completed shifts modulo 1024, and it changes only at the end of a write cycle.
- R3: When the write cycle completes at address 1023, the address becomes 0.
- R4: `mem_rd_wr` is 1 (read) in the idle state and in the read cycle. It is 0 (write) only in the write cycle.
- R5: After a request is accepted (`shift_req` high while `busy` low), `busy` stays high for exactly two cycles and then returns low.
- R6: A `shift_req` that arrives while `busy` is high starts no shift and does not move the address.
- R7: The stored bit is the `ser_in` value from the cycle in which the request was accepted. Changes to `ser_in` during the sequence have no effect.
- R8: `ser_out` changes only at the clock edge that ends a read cycle. At all other times it holds its value.
- R9: Synchronous active-high reset sets the address to 0, `ser_out` to 0, `busy` to 0 and `mem_rd_wr` to 1. Reset leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_req | input | 1 | Request for one shift; taken only while busy is low |
| ser_in | input | 1 | Serial data bit, sampled when the request is taken |
| ser_out | output | 1 | Registered serial output; the bit from 1024 shifts ago |
| busy | output | 1 | High during the two-cycle read/write sequence |
| mem_addr | output | 10 | Address currently applied to the memory |
| mem_rd_wr | output | 1 | Memory direction: 1 = read, 0 = write |

## Verification
The assertions assume that `shift_req` and `ser_in` are synchronous to `clk`. They also assume that reset is held for at least two cycles at start-up, so that no history check looks at a value from before the first edge. The bench changes every input on the falling edge. It holds the initial reset for three cycles. It applies the mid-run reset only when the address has wrapped to 0. That way the reference queue stays aligned with the retained memory contents, and it can show that reset does not erase stored bits. During each sequence, the bench deliberately raises `shift_req` again and toggles `ser_in`, to exercise the ignore and sampling rules.

// File: rtl/ram_shift_line_pkg.sv
package ram_shift_line_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rsl_sequencer.sv
module rsl_sequencer
  import ram_shift_line_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic din,
  output logic busy,
  output logic rd_strobe,
  output logic wr_strobe,
  output logic rd_wr,
  output logic din_hold
);
  seq_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      SEQ_IDLE:  if (req) st_nx = SEQ_READ;
      SEQ_READ:  st_nx = SEQ_WRITE;
      SEQ_WRITE: st_nx = SEQ_IDLE;
      default:   st_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      din_hold <= 1'b0;
    end else begin
      st <= st_nx;
      // capture the new bit only at acceptance
      if (st == SEQ_IDLE && req) din_hold <= din;
    end
  end

  assign busy      = (st != SEQ_IDLE);
  assign rd_strobe = (st == SEQ_READ);
  assign wr_strobe = (st == SEQ_WRITE);
  assign rd_wr     = (st != SEQ_WRITE);
endmodule

// File: rtl/rsl_addr_ctr.sv
module rsl_addr_ctr #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic [AW-1:0] addr_nx;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign addr_nx = addr + 1'b1;
    end else begin : g_mod
      assign addr_nx = (addr == LAST) ? '0 : addr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= addr_nx;
  end
endmodule

// File: rtl/rsl_bitram.sv
module rsl_bitram #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic          wdata,
  output logic          rdata
);
  logic mem [0:DEPTH-1];

  // array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  // output register doubles as the serial output stage
  always_ff @(posedge clk) begin
    if (rst)        rdata <= 1'b0;
    else if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/ram_shift_line.sv
module ram_shift_line #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_req,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_wr
);
  logic rd_strobe, wr_strobe, din_hold;

  rsl_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (shift_req),
    .din       (ser_in),
    .busy      (busy),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .rd_wr     (mem_rd_wr),
    .din_hold  (din_hold)
  );

  rsl_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .step (wr_strobe),
    .addr (mem_addr)
  );

  rsl_bitram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_strobe),
    .wr_en (wr_strobe),
    .addr  (mem_addr),
    .wdata (din_hold),
    .rdata (ser_out)
  );
endmodule

// File: rtl/ram_shift_line_chk.sv
module ram_shift_line_chk #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          shift_req,
  input logic          ser_out,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd_wr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assert_two_cycle_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && shift_req) |=> busy ##1 busy ##1 !busy);

  assert_read_then_write_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rd_wr) |=> (busy && !mem_rd_wr));

  assert_write_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_wr |-> busy);

  assert_same_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rd_wr) |=> $stable(mem_addr));

  assert_idle_addr_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(mem_addr));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_wr && mem_addr != LAST) |=> mem_addr == $past(mem_addr) + 1'b1);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_wr && mem_addr == LAST) |=> mem_addr == '0);

  assert_hold_out_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && mem_rd_wr) |=> $stable(ser_out));
endmodule

bind ram_shift_line ram_shift_line_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_req (shift_req),
  .ser_out   (ser_out),
  .busy      (busy),
  .mem_addr  (mem_addr),
  .mem_rd_wr (mem_rd_wr)
);

// File: tb/ram_shift_line_tb.sv
module ram_shift_line_tb;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shift_req = 1'b0;
  logic          ser_in = 1'b0;
  logic          ser_out, busy, mem_rd_wr;
  logic [AW-1:0] mem_addr;

  int total = 0;
  int bad = 0;
  int exp_addr = 0;
  int cycles = 0;
  bit post_rst = 1'b0;
  bit done = 1'b0;
  bit ref_q [$];

  always #2 clk = ~clk;

  ram_shift_line #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .shift_req(shift_req), .ser_in(ser_in),
    .ser_out(ser_out), .busy(busy), .mem_addr(mem_addr), .mem_rd_wr(mem_rd_wr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: in the write cycle ser_out carries this shift's result
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && busy && !mem_rd_wr && ref_q.size() > DEPTH) begin
        bit e;
        e = ref_q.pop_front();
        chk(ser_out == e, post_rst ? "R9 R1 R7" : "R1 R7", ser_out, e);
      end
    end
  end

  // driver: one shift with noise on the inputs during the sequence
  task automatic shift_one(input bit b);
    bit wrap;
    logic held;
    @(negedge clk);
    shift_req = 1'b1;
    ser_in    = b;
    ref_q.push_back(b);
    @(negedge clk);                       // read cycle
    chk(busy == 1'b1, "R5", busy, 1);
    chk(mem_rd_wr == 1'b1, "R4", mem_rd_wr, 1);
    chk(mem_addr == AW'(exp_addr), "R2", mem_addr, exp_addr);
    shift_req = 1'($urandom % 2);         // R6: request while busy
    ser_in    = ~b;                       // R7: change after acceptance
    @(negedge clk);                       // write cycle
    chk(busy == 1'b1, "R5", busy, 1);
    chk(mem_rd_wr == 1'b0, "R4", mem_rd_wr, 0);
    chk(mem_addr == AW'(exp_addr), "R2", mem_addr, exp_addr);
    shift_req = 1'($urandom % 2);
    ser_in    = 1'($urandom % 2);
    wrap = (exp_addr == DEPTH - 1);
    @(negedge clk);                       // back to idle
    shift_req = 1'b0;
    exp_addr  = (exp_addr + 1) % DEPTH;
    chk(busy == 1'b0, "R5 R6", busy, 0);
    chk(mem_rd_wr == 1'b1, "R4", mem_rd_wr, 1);
    chk(mem_addr == AW'(exp_addr), wrap ? "R3" : "R6", mem_addr, exp_addr);
    held = ser_out;
    repeat ($urandom % 4) begin
      @(negedge clk);
      ser_in = 1'($urandom % 2);
      chk(ser_out == held, "R8", ser_out, held);
      chk(mem_addr == AW'(exp_addr), "R2", mem_addr, exp_addr);
    end
  endtask

  task automatic check_reset_state();
    chk(ser_out == 1'b0, "R9", ser_out, 0);
    chk(busy == 1'b0, "R9", busy, 0);
    chk(mem_rd_wr == 1'b1, "R9", mem_rd_wr, 1);
    chk(mem_addr == '0, "R9", mem_addr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int i = 0; i < 2 * DEPTH; i++) shift_one(1'($urandom % 2));
    // address is 0 again here; reset must keep stored bits
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    post_rst = 1'b1;
    for (int i = 0; i < 1100; i++) shift_one(1'($urandom % 2));
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule